// File: doc/BRIEF.md
# Double-Precision Round and Pack Unit

This unit is the final stage of a double-precision arithmetic datapath. An upstream operator delivers a sign, a signed unbiased exponent and a 56-bit working mantissa. The top bit of that mantissa is the leading one, the next 52 bits are the fraction, and the bottom three bits are guard, round and sticky. The unit rounds the value in the selected mode, denormalizes it or flushes it to zero when it is too small, and saturates it when it is too large. It then packs the 64-bit IEEE 754 word.

The unit also keeps three accumulating exception flags: inexact, underflow and overflow. A result appears one clock after its input strobe, so a new operand can be accepted on every cycle. Exact zeros, NaNs and infinities must not be presented to the unit; the upstream logic handles them.

Top module: `dp_round_pack`

## Requirements
- R1: `out_valid` is high exactly one clock after `in_valid` was high. `out_result` holds the packed word of the operand accepted on that edge. After reset, `out_valid` and all three flags are 0.
- R2: When the three low mantissa bits are zero and the exponent lies in [-1022, 1023], the result is {sign, exponent+1023, mantissa[54:3]} and no flag is set.
- R3: `in_rmode` selects rounding: 2'b00 nearest-even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity. Rounding acts only when mantissa[2:0] is non-zero, and it then sets inexact. Nearest-even adds 3 plus mantissa bit 3. Toward +infinity adds 8 for a positive sign only, and toward -infinity adds 8 for a negative sign only. The three low bits are then dropped.
- R4: If the rounding addition carries out of bit 55, the mantissa shifts right by one and the exponent grows by one.
- R5: An exponent above 1023 after rounding sets overflow and inexact. The result is then signed infinity for nearest, signed largest finite for toward zero, +infinity or -largest for toward +infinity, and +largest or -infinity for toward -infinity.
- R6: With `in_ftz` high and an exponent below -1022, underflow and inexact are set. The result is signed zero in nearest and toward-zero modes. Toward +infinity gives the smallest positive denormal for a positive sign and -0 for a negative sign. Toward -infinity gives +0 for a positive sign and the smallest negative denormal for a negative sign.
- R7: Otherwise, an exponent below -1022 shifts the mantissa right by (-1022 - exponent) places and ORs every bit shifted out into bit 0. The shifted value is rounded and packed with biased exponent 0. It becomes the smallest normal if rounding reaches the leading bit. An inexact result whose leading bit was clear before rounding also sets underflow.
- R8: An exact denormal result sets underflow only when `in_uf_mask` is high.
- R9: With exponent -1023, if rounding the unshifted mantissa carries out of bit 55, the value is not tiny. The result is then the rounded mantissa shifted right by one with exponent -1022, and only inexact is set.
- R10: The flags accumulate over results until `flag_clr` is sampled high. A clear on the same edge as a new operand leaves only that operand's flags.
- R11: The unit never produces a NaN encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_sign | input | 1 | Sign of the operand |
| in_exp | input | 13 | Signed unbiased exponent |
| in_mant | input | 56 | Leading one, 52 fraction bits, guard/round/sticky |
| in_rmode | input | 2 | Rounding mode |
| in_ftz | input | 1 | Flush tiny results to zero |
| in_uf_mask | input | 1 | Report underflow on exact denormal results |
| flag_clr | input | 1 | Clear the accumulated flags |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Packed double |
| flag_inexact | output | 1 | Accumulated inexact flag |
| flag_underflow | output | 1 | Accumulated underflow flag |
| flag_overflow | output | 1 | Accumulated overflow flag |

## Verification
The hardest case to reach is the boundary exponent -1023. There, whether the operand is tiny depends on a rounding carry that occurs only when the whole fraction is ones and the guard bits push it over. The stimulus sets up that all-ones mantissa directly and repeats it in a mode that does not round up, so both branches are taken. Deep denormals and the flush-to-zero result table need exponents far below the minimum, with each sign in each mode. Directed sweeps cover those, and a long stream of mixed operands checked against a bit-serial reference model follows them.

// File: rtl/dp_rp_pkg.sv
package dp_rp_pkg;
    localparam int FRAC_W   = 52;
    localparam int EXPF_W   = 11;
    localparam int GRS_W    = 3;
    localparam int EXP_IN_W = 13;
    localparam int MANT_W   = FRAC_W + 1 + GRS_W;
    localparam int WORD_W   = 1 + EXPF_W + FRAC_W;
    localparam int XE_W     = EXP_IN_W + 1;
    localparam int BIAS     = (1 << (EXPF_W - 1)) - 1;
    localparam int EMIN     = 1 - BIAS;
    localparam int EMAX     = BIAS;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
        logic              nx;
        logic              uf;
        logic              ov;
    } rp_state_t;
endpackage

// File: rtl/dp_rp_incr.sv
module dp_rp_incr
    import dp_rp_pkg::*;
(
    input  logic              sign,
    input  logic [MANT_W-1:0] mant,
    input  rmode_e            rmode,
    output logic [MANT_W:0]   sum,
    output logic              lossy
);
    localparam logic [MANT_W:0] ULP_V  = (MANT_W + 1)'(1) << GRS_W;
    localparam logic [MANT_W:0] HALF_V = (MANT_W + 1)'((1 << (GRS_W - 1)) - 1);

    logic [MANT_W:0] addend;

    always_comb begin
        lossy  = |mant[GRS_W-1:0];
        addend = '0;
        if (lossy) begin
            case (rmode)
                RM_NEAR: addend = HALF_V + (MANT_W + 1)'(mant[GRS_W]);
                RM_ZERO: addend = '0;
                RM_UP:   addend = sign ? '0 : ULP_V;
                RM_DOWN: addend = sign ? ULP_V : '0;
                default: addend = '0;
            endcase
        end
        sum = {1'b0, mant} + addend;
    end

    always_comb begin
        if (!lossy) begin
            AST_EXACT_NO_BUMP: assert (sum[MANT_W-1:0] == mant && !sum[MANT_W]); // R3
        end
    end
endmodule

// File: rtl/dp_rp_srs.sv
module dp_rp_srs
    import dp_rp_pkg::*;
(
    input  logic [MANT_W-1:0] mant,
    input  logic [XE_W-1:0]   amt,
    output logic [MANT_W-1:0] shifted
);
    logic [MANT_W-1:0] lost_mask;
    logic              lost;

    always_comb begin
        lost_mask = '0;
        lost      = 1'b0;
        if (amt >= XE_W'(MANT_W)) begin
            shifted = {{(MANT_W-1){1'b0}}, |mant};
        end else begin
            lost_mask = ~({MANT_W{1'b1}} << amt);
            lost      = |(mant & lost_mask);
            shifted   = (mant >> amt) | {{(MANT_W-1){1'b0}}, lost};
        end
    end

    always_comb begin
        if (mant != '0) begin
            AST_SRS_KEEPS_NONZERO: assert (shifted != '0); // R7
        end
    end
endmodule

// File: rtl/dp_round_pack.sv
module dp_round_pack
    import dp_rp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sign,
    input  logic [EXP_IN_W-1:0] in_exp,
    input  logic [MANT_W-1:0]   in_mant,
    input  logic [1:0]          in_rmode,
    input  logic                in_ftz,
    input  logic                in_uf_mask,
    input  logic                flag_clr,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_result,
    output logic                flag_inexact,
    output logic                flag_underflow,
    output logic                flag_overflow
);
    localparam logic signed [XE_W-1:0] EMIN_V = XE_W'(EMIN);
    localparam logic signed [XE_W-1:0] EDGE_V = XE_W'(EMIN - 1);
    localparam logic signed [XE_W-1:0] EMAX_V = XE_W'(EMAX);
    localparam logic signed [XE_W-1:0] BIAS_V = XE_W'(BIAS);
    localparam logic [WORD_W-2:0] MAG_INF = {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [WORD_W-2:0] MAG_MAX = {{(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    localparam logic [WORD_W-2:0] MAG_MIN = (WORD_W-1)'(1);

    rp_state_t cur_q, nxt_d;
    rmode_e    rm;

    logic signed [XE_W-1:0] xe, e1, e2, biased;
    logic [XE_W-1:0]        sh_amt;
    logic                   is_tiny, edge_carry, toward_big;
    logic [MANT_W:0]        sum0, sum1;
    logic                   lossy0, lossy1;
    logic [MANT_W-1:0]      srs_out, m1, m2;
    logic [FRAC_W:0]        sig;
    logic [WORD_W-1:0]      word;
    logic                   nx, uf, ov;
    logic                   unused_bits;

    assign rm      = rmode_e'(in_rmode);
    assign xe      = {in_exp[EXP_IN_W-1], in_exp};
    assign is_tiny = xe < EMIN_V;
    assign sh_amt  = is_tiny ? XE_W'(EMIN_V - xe) : '0;

    // rounding of the operand as presented, used for the boundary test
    dp_rp_incr u_incr_raw (
        .sign  (in_sign),
        .mant  (in_mant),
        .rmode (rm),
        .sum   (sum0),
        .lossy (lossy0)
    );

    dp_rp_srs u_srs (
        .mant    (in_mant),
        .amt     (sh_amt),
        .shifted (srs_out)
    );

    // rounding of the aligned mantissa
    dp_rp_incr u_incr_fin (
        .sign  (in_sign),
        .mant  (m1),
        .rmode (rm),
        .sum   (sum1),
        .lossy (lossy1)
    );

    assign unused_bits = ^{sum0[GRS_W:0], m2[GRS_W-1:0], biased[XE_W-1:EXPF_W]};

    always_comb begin
        edge_carry = (xe == EDGE_V) && lossy0 && sum0[MANT_W];
        toward_big = 1'b0;

        // alignment
        if (is_tiny && edge_carry) begin
            m1 = {sum0[MANT_W:GRS_W+1], {GRS_W{1'b0}}};
            e1 = EMIN_V;
        end else if (is_tiny) begin
            m1 = srs_out;
            e1 = EMIN_V;
        end else begin
            m1 = in_mant;
            e1 = xe;
        end

        // rounding with carry renormalization
        if (lossy1 && sum1[MANT_W]) begin
            m2 = sum1[MANT_W:1];
            e2 = e1 + XE_W'(1);
        end else if (lossy1) begin
            m2 = sum1[MANT_W-1:0];
            e2 = e1;
        end else begin
            m2 = m1;
            e2 = e1;
        end
        sig    = m2[MANT_W-1:GRS_W];
        biased = e2 + BIAS_V;

        // packing
        nx   = 1'b0;
        uf   = 1'b0;
        ov   = 1'b0;
        word = '0;
        if (is_tiny && in_ftz) begin
            nx         = 1'b1;
            uf         = 1'b1;
            toward_big = (rm == RM_UP && !in_sign) || (rm == RM_DOWN && in_sign);
            word       = {in_sign, toward_big ? MAG_MIN : '0};
        end else begin
            nx = (is_tiny && edge_carry) || lossy1;
            uf = lossy1 && !m1[MANT_W-1];
            if (e2 > EMAX_V) begin
                ov         = 1'b1;
                nx         = 1'b1;
                toward_big = (rm == RM_NEAR) || (rm == RM_UP && !in_sign) ||
                             (rm == RM_DOWN && in_sign);
                word       = {in_sign, toward_big ? MAG_INF : MAG_MAX};
            end else if (!sig[FRAC_W]) begin
                uf   = uf || in_uf_mask;
                word = {in_sign, {EXPF_W{1'b0}}, sig[FRAC_W-1:0]};
            end else begin
                word = {in_sign, biased[EXPF_W-1:0], sig[FRAC_W-1:0]};
            end
        end

        // next state
        nxt_d.vld  = in_valid;
        nxt_d.word = in_valid ? word : cur_q.word;
        nxt_d.nx   = (cur_q.nx && !flag_clr) || (in_valid && nx);
        nxt_d.uf   = (cur_q.uf && !flag_clr) || (in_valid && uf);
        nxt_d.ov   = (cur_q.ov && !flag_clr) || (in_valid && ov);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign out_valid      = cur_q.vld;
    assign out_result     = cur_q.word;
    assign flag_inexact   = cur_q.nx;
    assign flag_underflow = cur_q.uf;
    assign flag_overflow  = cur_q.ov;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
    AST_OVF_WITH_INEXACT: assert property (@(posedge clk) disable iff (!rst_n) flag_overflow |-> flag_inexact); // R5
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag_underflow && !flag_clr) |=> flag_underflow); // R10
    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (flag_clr && !in_valid) |=> !(flag_inexact || flag_underflow || flag_overflow)); // R10
    AST_NEVER_NAN: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !((&out_result[WORD_W-2:FRAC_W]) && (|out_result[FRAC_W-1:0]))); // R11
endmodule

// File: tb/tb_dp_round_pack.sv
`timescale 1ns/1ps
module tb_dp_round_pack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [12:0] in_exp = '0;
    logic [55:0] in_mant = '0;
    logic [1:0]  in_rmode = '0;
    logic        in_ftz = 1'b0;
    logic        in_uf_mask = 1'b0;
    logic        flag_clr = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        flag_inexact, flag_underflow, flag_overflow;

    always #4 clk = ~clk;

    dp_round_pack dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_mant(in_mant), .in_rmode(in_rmode), .in_ftz(in_ftz),
        .in_uf_mask(in_uf_mask), .flag_clr(flag_clr), .out_valid(out_valid),
        .out_result(out_result), .flag_inexact(flag_inexact),
        .flag_underflow(flag_underflow), .flag_overflow(flag_overflow)
    );

    typedef struct {
        logic [63:0] word;
        logic [2:0]  flags;
        string       tag;
    } exp_item_t;

    exp_item_t   sb[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [2:0]  model_flags = '0;
    bit          done = 1'b0;

    localparam logic [55:0] ONE  = 56'h80_0000_0000_0000;
    localparam logic [55:0] ALL1 = 56'hFF_FFFF_FFFF_FFFF;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic longint unsigned bump(bit s, longint unsigned x, bit [1:0] rm);
        if ((x & 64'd7) == 0) return x;
        case (rm)
            2'b00: return x + 3 + ((x >> 3) & 1);
            2'b01: return x;
            2'b10: return s ? x : x + 8;
            default: return s ? x + 8 : x;
        endcase
    endfunction

    function automatic void model(input bit s, input int e, input logic [55:0] m,
                                  input bit [1:0] rm, input bit ftz, input bit ufm,
                                  output logic [63:0] r, output logic [2:0] f);
        longint unsigned x = 64'(m);
        int              ex = e;
        bit              nx = 0, uf = 0, ov = 0;
        logic [63:0]     xv;
        logic [10:0]     be;
        bit              big;
        if (ex < -1022 && ftz) begin
            big = (rm == 2'b10 && !s) || (rm == 2'b11 && s);
            r = {s, 63'(big ? 1 : 0)};
            f = 3'b110;
            return;
        end
        if (ex < -1022) begin
            if (ex == -1023 && (bump(s, x, rm) >> 56) != 0) begin
                nx = 1;
                x  = (bump(s, x, rm) >> 1) & ~64'd7;
                ex = -1022;
            end else begin
                while (ex < -1022) begin
                    x = (x >> 1) | (x & 1);
                    ex++;
                end
            end
        end
        if ((x & 7) != 0) begin
            nx = 1;
            if (((x >> 55) & 1) == 0) uf = 1;
            x = bump(s, x, rm);
            if ((x >> 56) != 0) begin
                x = x >> 1;
                ex++;
            end
        end
        x  = x >> 3;
        xv = x;
        if (ex > 1023) begin
            big = (rm == 2'b00) || (rm == 2'b10 && !s) || (rm == 2'b11 && s);
            r = big ? {s, 11'h7FF, 52'h0} : {s, 11'h7FE, {52{1'b1}}};
            f = 3'b101;
            return;
        end
        if (xv[52] == 1'b0) begin
            if (ufm) uf = 1;
            r = {s, 11'h000, xv[51:0]};
        end else begin
            be = 11'(ex + 1023);
            r  = {s, be, xv[51:0]};
        end
        f = {nx, uf, ov};
    endfunction

    task automatic drive(input bit s, input int e, input logic [55:0] m, input bit [1:0] rm,
                         input bit ftz, input bit ufm, input bit clr, input string tag);
        exp_item_t  it;
        logic [2:0] f;
        @(negedge clk);
        model(s, e, m, rm, ftz, ufm, it.word, f);
        if (clr) model_flags = '0;
        model_flags = model_flags | f;
        it.flags = model_flags;
        it.tag   = tag;
        sb.push_back(it);
        in_valid   = 1'b1;
        in_sign    = s;
        in_exp     = 13'(e);
        in_mant    = m;
        in_rmode   = rm;
        in_ftz     = ftz;
        in_uf_mask = ufm;
        flag_clr   = clr;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        flag_clr = 1'b0;
    endtask

    // monitor
    initial begin
        exp_item_t it;
        while (!done) begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R1", "unexpected out_valid", 64'(out_valid), 64'd0);
                end else begin
                    it = sb.pop_front();
                    check(out_result === it.word, it.tag, "result", out_result, it.word);
                    check({flag_inexact, flag_underflow, flag_overflow} === it.flags, it.tag,
                          "flags nx/uf/ov", 64'({flag_inexact, flag_underflow, flag_overflow}),
                          64'(it.flags));
                    check(!((&out_result[62:52]) && (|out_result[51:0])), "R11", "NaN produced",
                          out_result, 64'h0);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R1", "watchdog expired", 64'd0, 64'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [55:0] rm_mant;
        int          rexp;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !flag_inexact && !flag_underflow && !flag_overflow, "R1",
              "reset state", 64'({out_valid, flag_inexact, flag_underflow, flag_overflow}), 64'd0);

        // R2 exact normals
        drive(0, 0, ONE, 2'b00, 0, 0, 1, "R2");
        drive(1, -1022, ONE | 56'h8, 2'b01, 0, 1, 1, "R2");
        drive(0, 1023, ALL1 & ~56'h7, 2'b10, 0, 0, 1, "R2");
        // R3 rounding modes
        drive(0, 0, ONE | 56'h4, 2'b00, 0, 0, 1, "R3");
        drive(0, 0, ONE | 56'hC, 2'b00, 0, 0, 1, "R3");
        drive(1, 3, ONE | 56'h5, 2'b00, 0, 0, 1, "R3");
        drive(0, 0, ONE | 56'h7, 2'b01, 0, 0, 1, "R3");
        drive(0, 0, ONE | 56'h1, 2'b10, 0, 0, 1, "R3");
        drive(1, 0, ONE | 56'h1, 2'b10, 0, 0, 1, "R3");
        drive(0, 0, ONE | 56'h1, 2'b11, 0, 0, 1, "R3");
        drive(1, 0, ONE | 56'h1, 2'b11, 0, 0, 1, "R3");
        // R4 carry
        drive(0, 0, ALL1, 2'b00, 0, 0, 1, "R4");
        drive(0, 5, ALL1, 2'b10, 0, 0, 1, "R4");
        // R5 overflow table
        for (int md = 0; md < 4; md++)
            for (int sg = 0; sg < 2; sg++)
                drive(sg[0], 1024, ONE, md[1:0], 0, 0, 1, "R5");
        drive(1, 1023, ALL1, 2'b00, 0, 0, 1, "R5");
        // R6 flush-to-zero table
        for (int md = 0; md < 4; md++)
            for (int sg = 0; sg < 2; sg++)
                drive(sg[0], -1023 - 400 * sg, ONE | 56'h3, md[1:0], 1, 0, 1, "R6");
        // R7 gradual underflow
        drive(0, -1030, ONE | 56'h1, 2'b00, 0, 0, 1, "R7");
        drive(0, -1100, ONE, 2'b00, 0, 0, 1, "R7");
        drive(0, -1100, ONE, 2'b10, 0, 0, 1, "R7");
        drive(1, -1026, ALL1, 2'b11, 0, 0, 1, "R7");
        // R8 exact denormal with and without the mask
        drive(0, -1023, ONE, 2'b00, 0, 0, 1, "R8");
        drive(0, -1023, ONE, 2'b00, 0, 1, 1, "R8");
        // R9 boundary exponent
        drive(0, -1023, ALL1, 2'b00, 0, 0, 1, "R9");
        drive(0, -1023, ALL1, 2'b01, 0, 0, 1, "R9");
        // R10 accumulation without clears
        drive(0, 1024, ONE, 2'b00, 0, 0, 0, "R10");
        drive(0, -1100, ONE, 2'b00, 0, 0, 0, "R10");
        drive(0, 0, ONE, 2'b00, 0, 0, 0, "R10");
        // R10 clear while idle
        @(negedge clk);
        in_valid = 1'b0;
        flag_clr = 1'b1;
        model_flags = '0;
        @(negedge clk);
        flag_clr = 1'b0;
        check(!flag_inexact && !flag_underflow && !flag_overflow, "R10", "flags after clear",
              64'({flag_inexact, flag_underflow, flag_overflow}), 64'd0);

        // mixed stream
        for (int i = 0; i < 400; i++) begin
            rm_mant = {1'b1, 23'($urandom), 32'($urandom)};
            if (i % 5 == 0) rm_mant[2:0] = 3'b000;
            rexp = int'($urandom % 2201) - 1100;
            drive($urandom % 2 == 1, rexp, rm_mant, 2'($urandom), ($urandom % 4) == 0,
                  $urandom % 2 == 1, ($urandom % 3) == 0, "R3");
        end
        idle();
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R1", "results outstanding", 64'(sb.size()), 64'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule